// File: doc/BRIEF.md
# Ethernet switch tag inserter

This block sits on the transmit path from a host CPU into a managed Ethernet switch. It adds a fixed 8-byte management tag to every frame it carries. The tag tells the switch which single port the frame must leave on, and that the switch must not learn the source address of the frame. Frames enter and leave one byte per beat on a stream interface with valid, ready and last.

A static placement input selects where the tag goes. In header placement the tag follows the two 6-byte MAC addresses and comes before the original type field. In trailer placement the tag follows the final payload byte, so it sits where a CRC would later be appended. While the tag bytes go out, the input is stalled. Outside the tag the block is a zero-latency pass-through, so valid and ready cross it within the same cycle.

The block samples the egress port index and the placement on the first beat of each frame. It holds both until that frame is finished, and turns the index into a one-hot forwarding mask. It adds no FCS and no padding, and it does not recompute checksums.

Top module: `swtag_inserter`

## Requirements
- R1: Tag bytes 0 to 3, in output order, are 0x88, 0x99, 0x04, 0x00. These are the type value 0x8899 and then protocol code 0x04 followed by a zero reason byte. Each 16-bit word goes most-significant byte first.
- R2: Tag bytes 4 and 5 are 0x00 and 0x20. Only bit 5 (learn disable) of the third word is set.
- R3: Tag bytes 6 and 7 form a 16-bit word, high byte first. Bit 15 (allowance mode) is 0, bits 14:11 are 0, and bits 10:0 hold a mask with exactly one bit set, at position port_idx_i, when port_idx_i is 10 or less.
- R4: With mode_i = 0 (header placement), the 8 tag bytes are emitted directly after input byte 11 (the 12th byte) and before input byte 12. The output last flag is on the frame's final input byte.
- R5: With header placement, a frame of 12 bytes or fewer is passed through unchanged, with no tag.
- R6: With mode_i = 1 (trailer placement), all input bytes pass unchanged with last cleared, and are followed by the 8 tag bytes. The output last flag is on tag byte 7 only.
- R7: While tag bytes are being emitted, s_tready is 0 and m_tvalid is 1. A tag byte is held until m_tready accepts it.
- R8: Outside the tag, m_tvalid equals s_tvalid, s_tready equals m_tready, and m_tdata equals s_tdata in the same cycle.
- R9: mode_i and port_idx_i are sampled on the first accepted beat of a frame. Changes to them later in the frame have no effect on that frame.
- R10: A port index above 10 gives an all-zero mask. It also sets port_err_o from the cycle after that frame's first beat, and port_err_o stays set until reset.
- R11: A synchronous active-low reset returns the block to the start of a frame, with port_err_o = 0 and no output valid while the input is idle. A frame cut off by reset leaves no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | Tag placement: 0 header, 1 trailer |
| port_idx_i | input | 4 | Egress port index for the frame |
| s_tdata | input | 8 | Input stream byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tlast | input | 1 | Input byte is the last of the frame |
| s_tready | output | 1 | Block accepts the input byte |
| m_tdata | output | 8 | Output stream byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tlast | output | 1 | Output byte is the last of the frame |
| m_tready | input | 1 | Sink accepts the output byte |
| port_err_o | output | 1 | Sticky flag: an out-of-range port index was seen |

## Verification
Pass-through results (m_tvalid, s_tready, m_tdata and m_tlast outside the tag) depend only on the inputs of the same cycle. The bench therefore drives each cycle's inputs just after the falling edge and checks them a short settle time later, before the next rising edge. A tag byte appears in the cycle after the handshake of the byte before it, and it advances only on a cycle where m_tready is high. The bench walks an expected byte list and compares each output handshake against its next entry, so that any stall pattern is covered. port_err_o changes one rising edge after the first beat is accepted, and is checked only after the frame has ended.

// File: rtl/swtag_pkg.sv
// Shared constants and types for the switch tag inserter.
// Assumes a byte-wide stream and an 8-byte tag made of four big-endian words.
package swtag_pkg;
    localparam int BYTE_W    = 8;
    localparam int TAG_BYTES = 8;
    localparam int TAG_SEL_W = $clog2(TAG_BYTES);

    localparam logic [15:0] TAG_TYPE_WORD = 16'h8899;
    localparam logic [7:0]  TAG_PROTO     = 8'h04;
    localparam int          LEARN_OFF_BIT = 5;

    typedef enum logic {
        PLACE_HEADER  = 1'b0,
        PLACE_TRAILER = 1'b1
    } place_mode_t;

    typedef enum logic {
        SEQ_PASS = 1'b0,
        SEQ_TAG  = 1'b1
    } seq_state_t;
endpackage

// File: rtl/swtag_field_gen.sv
// Builds the tag byte for a given beat number from the egress port index.
// Purely combinational. Assumes NUM_PORTS <= 15, so the mask fits below the allowance bit.
module swtag_field_gen
    import swtag_pkg::*;
#(
    parameter int NUM_PORTS = 11,
    parameter int IDX_W     = 4
) (
    input  logic [IDX_W-1:0]     port_idx,
    input  logic [TAG_SEL_W-1:0] beat_sel,
    output logic [BYTE_W-1:0]    tag_byte,
    output logic [NUM_PORTS-1:0] fwd_mask
);
    localparam int PAD_W = 16 - NUM_PORTS;

    logic [15:0] word_q [4];

    // One decoder bit per port; out-of-range indexes match none.
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_mask
        assign fwd_mask[g] = (port_idx == IDX_W'(g));
    end

    // Assemble the four tag words.
    always_comb begin
        word_q[0] = TAG_TYPE_WORD;
        word_q[1] = {TAG_PROTO, 8'h00};
        word_q[2] = 16'(1) << LEARN_OFF_BIT;
        word_q[3] = {PAD_W'(0), fwd_mask};
    end

    // Pick the word, then the byte within it, high byte first.
    always_comb begin
        if (beat_sel[0] == 1'b0) tag_byte = word_q[beat_sel[TAG_SEL_W-1:1]][15:8];
        else                     tag_byte = word_q[beat_sel[TAG_SEL_W-1:1]][7:0];
    end
endmodule

// File: rtl/swtag_seq.sv
// Frame sequencer: counts header bytes, decides when the tag is inserted,
// and steers valid, ready and last. Assumes a source and sink that follow
// valid/ready rules. The tag beats come from this module's beat counter.
module swtag_seq
    import swtag_pkg::*;
#(
    parameter int HDR_BYTES = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic                 s_tvalid,
    input  logic                 s_tlast,
    output logic                 s_tready,
    output logic                 m_tvalid,
    output logic                 m_tlast,
    input  logic                 m_tready,
    output logic                 use_tag,
    output logic [TAG_SEL_W-1:0] tag_beat,
    output logic                 first_beat
);
    localparam int HCNT_W = $clog2(HDR_BYTES + 1);

    seq_state_t        state;
    logic [HCNT_W-1:0] hcnt;
    logic              mode_q;
    logic              mode_eff;
    logic              hs_in;

    assign use_tag    = (state == SEQ_TAG);
    assign first_beat = (state == SEQ_PASS) && (hcnt == '0);
    assign mode_eff   = first_beat ? mode_i : mode_q;
    assign hs_in      = s_tvalid && s_tready;

    // Handshake steering: pass-through outside the tag, source stalled during it.
    always_comb begin
        if (use_tag) begin
            m_tvalid = 1'b1;
            s_tready = 1'b0;
            m_tlast  = (mode_q == PLACE_TRAILER) && (tag_beat == TAG_SEL_W'(TAG_BYTES - 1));
        end else begin
            m_tvalid = s_tvalid;
            s_tready = m_tready;
            m_tlast  = s_tlast && (mode_eff == PLACE_HEADER);
        end
    end

    // State, header byte count, tag beat count and latched placement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_PASS;
            hcnt     <= '0;
            tag_beat <= '0;
            mode_q   <= PLACE_HEADER;
        end else if (state == SEQ_PASS) begin
            if (hs_in) begin
                if (first_beat) mode_q <= mode_i;
                if (s_tlast) begin
                    hcnt <= '0;
                    if (mode_eff == PLACE_TRAILER) begin
                        state    <= SEQ_TAG;
                        tag_beat <= '0;
                    end
                end else if (mode_eff == PLACE_HEADER && hcnt == HCNT_W'(HDR_BYTES - 1)) begin
                    state    <= SEQ_TAG;
                    tag_beat <= '0;
                    hcnt     <= HCNT_W'(HDR_BYTES);
                end else if (hcnt != HCNT_W'(HDR_BYTES)) begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end else if (m_tready) begin
            if (tag_beat == TAG_SEL_W'(TAG_BYTES - 1)) state <= SEQ_PASS;
            else                                       tag_beat <= tag_beat + 1'b1;
        end
    end

    // A stalled tag beat stays put.
    AST_TAG_HELD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (use_tag && !m_tready) |=> (use_tag && $stable(tag_beat))); // R7

    // The tag always ends after its final beat.
    AST_TAG_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(use_tag) |-> ($past(tag_beat) == TAG_SEL_W'(TAG_BYTES - 1))); // R7

    // A header tag starts only after the two MAC addresses.
    AST_HDR_TAG_AFTER_MACS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(use_tag) && mode_q == PLACE_HEADER) |-> ($past(hcnt) == HCNT_W'(HDR_BYTES - 1))); // R4
endmodule

// File: rtl/swtag_inserter.sv
// Top of the switch tag inserter. Latches the port index on each frame's
// first beat, keeps the sticky range-error flag, and multiplexes tag bytes
// into the stream. Assumes the port index fits in IDX_W bits.
module swtag_inserter
    import swtag_pkg::*;
#(
    parameter int NUM_PORTS = 11,
    parameter int IDX_W     = 4,
    parameter int HDR_BYTES = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_i,
    input  logic [IDX_W-1:0]   port_idx_i,
    input  logic [BYTE_W-1:0]  s_tdata,
    input  logic               s_tvalid,
    input  logic               s_tlast,
    output logic               s_tready,
    output logic [BYTE_W-1:0]  m_tdata,
    output logic               m_tvalid,
    output logic               m_tlast,
    input  logic               m_tready,
    output logic               port_err_o
);
    logic [IDX_W-1:0]     port_q;
    logic                 use_tag;
    logic                 first_beat;
    logic [TAG_SEL_W-1:0] tag_beat;
    logic [BYTE_W-1:0]    tag_byte;
    logic [NUM_PORTS-1:0] fwd_mask;
    logic                 first_hs;

    assign first_hs = first_beat && s_tvalid && s_tready;

    swtag_seq #(.HDR_BYTES(HDR_BYTES)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .s_tvalid   (s_tvalid),
        .s_tlast    (s_tlast),
        .s_tready   (s_tready),
        .m_tvalid   (m_tvalid),
        .m_tlast    (m_tlast),
        .m_tready   (m_tready),
        .use_tag    (use_tag),
        .tag_beat   (tag_beat),
        .first_beat (first_beat)
    );

    swtag_field_gen #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) gen_i (
        .port_idx (port_q),
        .beat_sel (tag_beat),
        .tag_byte (tag_byte),
        .fwd_mask (fwd_mask)
    );

    // Sample the port index on the first beat; hold it for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n)        port_q <= '0;
        else if (first_hs) port_q <= port_idx_i;
    end

    // Raise the range error on a bad index; only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                             port_err_o <= 1'b0;
        else if (first_hs && port_idx_i >= IDX_W'(NUM_PORTS))   port_err_o <= 1'b1;
    end

    // Output byte: tag byte during insertion, input byte otherwise.
    assign m_tdata = use_tag ? tag_byte : s_tdata;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        port_err_o |=> port_err_o); // R10

    AST_MASK_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q < IDX_W'(NUM_PORTS)) |-> $onehot(fwd_mask)); // R3

    AST_MASK_EMPTY_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (port_q >= IDX_W'(NUM_PORTS)) |-> (fwd_mask == '0)); // R10
endmodule

// File: tb/swtag_inserter_tb_top.sv
module swtag_inserter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_i = 1'b0;
    logic [3:0] port_idx_i = 4'd0;
    logic [7:0] s_tdata = 8'd0;
    logic       s_tvalid = 1'b0;
    logic       s_tlast = 1'b0;
    logic       s_tready;
    logic [7:0] m_tdata;
    logic       m_tvalid;
    logic       m_tlast;
    logic       m_tready = 1'b1;
    logic       port_err_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    logic [7:0] exp_d [0:127];
    logic       exp_l [0:127];
    logic       exp_t [0:127];
    string      exp_r [0:127];
    int         exp_n;

    always #10 clk = ~clk;

    swtag_inserter dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .port_idx_i(port_idx_i),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
        .port_err_o(port_err_o)
    );

    // Vector table: placement mode, port index, frame length in bytes.
    localparam int NVEC = 10;
    localparam int VEC_MODE [NVEC] = '{0, 0, 0, 1, 1, 0, 0, 1, 1, 0};
    localparam int VEC_PORT [NVEC] = '{0, 5, 10, 3, 7, 2, 9, 10, 0, 1};
    localparam int VEC_LEN  [NVEC] = '{20, 13, 30, 1, 15, 12, 5, 64, 9, 14};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    function automatic logic [7:0] pay(input int f, input int i);
        return 8'(f * 37 + i * 11 + 1);
    endfunction

    // Build the expected output stream from the requirements.
    task automatic build_exp(input int f, input int md, input int pt, input int len);
        logic [15:0] m16;
        logic [7:0]  tg [8];
        int k;
        m16 = (pt <= 10) ? (16'(1) << pt) : 16'h0000;
        tg = '{8'h88, 8'h99, 8'h04, 8'h00, 8'h00, 8'h20, m16[15:8], m16[7:0]};
        k = 0;
        for (int i = 0; i < len; i++) begin
            if (md == 0 && len > 12 && i == 12) begin
                for (int j = 0; j < 8; j++) begin
                    exp_d[k] = tg[j]; exp_l[k] = 1'b0; exp_t[k] = 1'b1;
                    exp_r[k] = (j < 4) ? "R1" : (j < 6) ? "R2" : "R3";
                    k++;
                end
            end
            exp_d[k] = pay(f, i);
            exp_l[k] = (md == 0) && (i == len - 1);
            exp_t[k] = 1'b0;
            exp_r[k] = (md == 1) ? "R6" : (len <= 12) ? "R5" : "R4";
            k++;
        end
        if (md == 1) begin
            for (int j = 0; j < 8; j++) begin
                exp_d[k] = tg[j]; exp_l[k] = (j == 7); exp_t[k] = 1'b1;
                exp_r[k] = (j < 4) ? "R1" : (j < 6) ? "R2" : "R3";
                k++;
            end
        end
        exp_n = k;
    endtask

    // Send one frame with irregular valid/ready, changing mode and port mid-frame (R9).
    task automatic run_frame(input int f, input int md, input int pt, input int len);
        int in_i = 0;
        int out_k = 0;
        int cyc = 0;
        build_exp(f, md, pt, len);
        while (out_k < exp_n) begin
            @(negedge clk);
            m_tready = ((cyc * 7 + f) % 5) != 0;
            if (in_i < len) begin
                s_tvalid = ((cyc * 3 + f) % 4) != 0;
                s_tdata  = pay(f, in_i);
                s_tlast  = (in_i == len - 1);
            end else begin
                s_tvalid = 1'b0;
                s_tlast  = 1'b0;
            end
            if (in_i == 0) begin
                mode_i = md[0]; port_idx_i = 4'(pt);
            end else begin
                mode_i = ~md[0]; port_idx_i = 4'(pt + 3);
            end
            #2;
            if (exp_t[out_k]) begin
                check(m_tvalid == 1'b1, "R7", "tag valid", m_tvalid, 1);
                check(s_tready == 1'b0, "R7", "ready low in tag", s_tready, 0);
            end else begin
                check(m_tvalid == s_tvalid, "R8", "valid pass", m_tvalid, s_tvalid);
                check(s_tready == m_tready, "R8", "ready pass", s_tready, m_tready);
            end
            if (m_tvalid && m_tready) begin
                check(m_tdata == exp_d[out_k], {exp_r[out_k], "/R9"}, "data", m_tdata, exp_d[out_k]);
                check(m_tlast == exp_l[out_k], {exp_r[out_k], "/R6"}, "last", m_tlast, exp_l[out_k]);
                out_k++;
            end
            if (s_tvalid && s_tready) in_i++;
            cyc++;
        end
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0; m_tready = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        s_tvalid = 1'b0; s_tlast = 1'b0; m_tready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_up();
        end
    end

    initial begin
        do_reset();
        #2;
        // R11: reset state
        check(m_tvalid == 1'b0, "R11", "idle valid", m_tvalid, 0);
        check(port_err_o == 1'b0, "R11", "err after reset", port_err_o, 0);
        check(s_tready == 1'b1, "R11", "ready idle", s_tready, 1);

        for (int v = 0; v < NVEC; v++) begin
            run_frame(v, VEC_MODE[v], VEC_PORT[v], VEC_LEN[v]);
        end
        #2;
        check(port_err_o == 1'b0, "R10", "no err for valid ports", port_err_o, 0);

        // R10: out-of-range port gives empty mask and sticky error
        run_frame(20, 0, 12, 16);
        #2;
        check(port_err_o == 1'b1, "R10", "err set", port_err_o, 1);
        run_frame(21, 1, 15, 4);
        run_frame(22, 0, 4, 14);
        #2;
        check(port_err_o == 1'b1, "R10", "err sticky", port_err_o, 1);

        // R11: reset mid-frame clears error and frame position
        @(negedge clk);
        mode_i = 1'b0; port_idx_i = 4'd6;
        for (int i = 0; i < 5; i++) begin
            s_tvalid = 1'b1; s_tdata = 8'hEE; s_tlast = 1'b0;
            @(negedge clk);
        end
        do_reset();
        #2;
        check(port_err_o == 1'b0, "R11", "err cleared by reset", port_err_o, 0);
        run_frame(30, 0, 6, 18);
        run_frame(31, 1, 8, 3);

        finish_up();
    end
endmodule